// File: doc/BRIEF.md
# Switchbox DMA Transfer Sequencer

This block moves bytes between memory channels and peripheral agents through a switchbox. Each command names a memory channel, a peripheral and a byte count. Channels 0 to 2 read memory and feed a peripheral. Channels 3 to 5 take bytes from a peripheral and write them to memory. The sequencer first links the two ends through the switchbox. It then arms the source and then arms the destination. Every open route has a small FIFO that can hold bytes the destination has not yet taken.

Completion is reported in two halves. The source half ends when the last byte has entered the fabric. The destination half ends when the last byte has left it. Each half sets a sticky flag, but only if the agent on that side has an interrupt line. The route stays open until the destination has taken every byte. A peripheral without an interrupt line must also report ready through its command-ready input before the route closes. After that, one drain cycle passes before the route is released. A poll word shows software the command-ready state and the route state of any peripheral.

Top module: `sbox_xfer_seq`

## Requirements
- R1: A command accepted at a clock edge is answered by `cmd_ok` in the following cycle. The route links in that cycle and offers no handshake. The source handshake is offered from the second edge after acceptance on, and the destination sees valid data no earlier than the third edge.
- R2: The source-half flag sets at the edge where the last of the N bytes enters the fabric, even while the destination has taken none of them. Flag bits 0 to 2 belong to read channels 0 to 2, bits 3 to 5 to write channels 3 to 5, and bits 6 and 7 to peripherals 0 and 1.
- R3: The destination-half flag sets at the first edge after the handshake of the final destination byte.
- R4: A route stays busy while any byte is undelivered. Its `route_busy` bit clears at the second edge after the final destination handshake.
- R5: Peripheral 1 has no interrupt line, so flag bit 7 never sets. A route whose destination is peripheral 1 stays busy after all bytes are delivered until `p_cmd_rdy[1]` is 1. It is released two edges after that. Bit 31 of `poll_word` mirrors the command-ready input of the peripheral chosen by `poll_sel` (1 = ready, 0 = busy), and bit 0 is 1 while an open route holds that peripheral.
- R6: A command naming a channel that is busy, or a peripheral held by any open route, is refused. `cmd_rej` pulses and the existing route continues unaffected.
- R7: A command with a count of 0, or with a channel index of 6 or more, is refused and starts no route.
- R8: After reset all flags, enables, the error bit and all `route_busy` bits are 0. `irq` is the OR of flags whose enable bit is set. Writing 1 to a bit through `irq_clr_wdata` clears that flag, and bits written 0 are untouched.
- R9: Bytes reach the destination unchanged and in source order, for counts both below and above the FIFO depth of 4.
- R10: On a write channel the peripheral is the source and memory is the destination. A peripheral with an interrupt line gets the source-half flag, and the write channel gets the destination-half flag.
- R11: Every refused command sets `err_flag`, which stays set until a clear write with bit 8 of `irq_clr_wdata` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_chan | input | 3 | Memory channel index (0-2 read, 3-5 write) |
| cmd_periph | input | 1 | Peripheral index |
| cmd_len | input | 16 | Byte count N |
| cmd_ok | output | 1 | Command accepted (one cycle) |
| cmd_rej | output | 1 | Command refused (one cycle) |
| mrd_valid | input | 3 | Memory read byte valid, per read channel |
| mrd_data | input | 24 | Memory read bytes, 8 bits per read channel |
| mrd_ready | output | 3 | Memory read byte taken |
| mwr_valid | output | 3 | Memory write byte valid, per write channel |
| mwr_data | output | 24 | Memory write bytes |
| mwr_ready | input | 3 | Memory write byte taken |
| prx_valid | output | 2 | Byte valid toward peripheral |
| prx_data | output | 16 | Bytes toward peripherals |
| prx_ready | input | 2 | Peripheral takes byte |
| ptx_valid | input | 2 | Byte valid from peripheral |
| ptx_data | input | 16 | Bytes from peripherals |
| ptx_ready | output | 2 | Fabric takes peripheral byte |
| p_cmd_rdy | input | 2 | Peripheral command-ready flags |
| poll_sel | input | 1 | Peripheral chosen for the poll word |
| poll_word | output | 32 | Bit 31 command-ready, bit 0 route held |
| route_busy | output | 6 | Route open, per channel |
| irq_en_we | input | 1 | Enable register write strobe |
| irq_en_wdata | input | 8 | New enable bits |
| irq_clr_we | input | 1 | Clear write strobe |
| irq_clr_wdata | input | 9 | Flags to clear; bit 8 clears the error bit |
| irq_flags | output | 8 | Sticky completion flags |
| err_flag | output | 1 | Sticky refusal bit |
| irq | output | 1 | Interrupt request |

## Verification
Suppose a route counter or state register goes wrong. The first thing it breaks is the release edge: `route_busy` falls one edge early or late, or stays high for good. The destination flag moves with it and shows up one edge away from where R3 puts it. An owner map that has lost track lets a second command claim a peripheral that is still held, and this shows on `cmd_ok` in the very next cycle. A FIFO pointer fault shows on the first byte that passes the wrapped slot, as a byte that is out of order or repeated.

// File: rtl/sbx_pkg.sv
`timescale 1ns/1ps
package sbx_pkg;
   typedef enum logic [2:0] {
      RT_IDLE,
      RT_LINK,
      RT_SRC,
      RT_XFER,
      RT_DRAIN
   } rt_state_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/sbx_fifo.sv
`timescale 1ns/1ps
module sbx_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          full,
   output logic          empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sbx_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DW-1:0] store [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;

   always_ff @(posedge clk) begin
      if (push) store[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + AW'(1);
         if (pop)  rp <= rp + AW'(1);
         case ({push, pop})
            2'b10:   cnt <= cnt + (AW+1)'(1);
            2'b01:   cnt <= cnt - (AW+1)'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign rdata = store[rp];
   assign full  = (cnt == (AW+1)'(DEPTH));
   assign empty = (cnt == '0);

   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/sbx_route.sv
`timescale 1ns/1ps
module sbx_route
   import sbx_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  len_in,
   input  logic              dst_poll,
   input  logic              dst_rdy,
   input  logic              s_valid,
   input  logic [BYTE_W-1:0] s_data,
   output logic              s_ready,
   output logic              d_valid,
   output logic [BYTE_W-1:0] d_data,
   input  logic              d_ready,
   output logic              busy,
   output logic              src_done,
   output logic              dst_done
);
   rt_state_e        st, st_nx;
   logic [CNT_W-1:0] len_q, src_cnt, dst_cnt;
   logic             f_full, f_empty, push, pop, src_on, dst_on, dst_ok;

   assign src_on  = (st == RT_SRC) || (st == RT_XFER);
   assign dst_on  = (st == RT_XFER);
   assign s_ready = src_on && (src_cnt != len_q) && !f_full;
   assign push    = s_valid && s_ready;
   assign d_valid = dst_on && !f_empty;
   assign pop     = d_valid && d_ready;
   assign dst_ok  = (dst_cnt == len_q) && (!dst_poll || dst_rdy);

   assign busy     = (st != RT_IDLE);
   assign src_done = push && (src_cnt == len_q - CNT_W'(1));
   assign dst_done = dst_on && dst_ok;

   always_comb begin
      st_nx = st;
      case (st)
         RT_IDLE:  if (start) st_nx = RT_LINK;
         RT_LINK:  st_nx = RT_SRC;
         RT_SRC:   st_nx = RT_XFER;
         RT_XFER:  if (dst_ok) st_nx = RT_DRAIN;
         RT_DRAIN: st_nx = RT_IDLE;
         default:  st_nx = RT_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RT_IDLE;
         len_q   <= '0;
         src_cnt <= '0;
         dst_cnt <= '0;
      end else begin
         st <= st_nx;
         if (st == RT_IDLE && start) begin
            len_q   <= len_in;
            src_cnt <= '0;
            dst_cnt <= '0;
         end else begin
            if (push) src_cnt <= src_cnt + CNT_W'(1);
            if (pop)  dst_cnt <= dst_cnt + CNT_W'(1);
         end
      end
   end

   sbx_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .wdata (s_data),
      .pop   (pop),
      .rdata (d_data),
      .full  (f_full),
      .empty (f_empty)
   );

   // R4: the route cannot close while bytes remain undelivered
   a_r4_hold_open: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dst_cnt != len_q) |=> busy);
   a_r4_release_complete: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(dst_cnt) == $past(len_q)));
   // R1: the source is never offered in the cycle right after the route opens
   a_r1_src_after_link: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> $past(busy));
   a_r2_src_done_in_route: assert property (@(posedge clk) disable iff (!rst_n)
      src_done |-> busy);
endmodule

// File: rtl/sbx_irq_ctl.sv
`timescale 1ns/1ps
module sbx_irq_ctl #(
   parameter int NF = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set_vec,
   input  logic          en_we,
   input  logic [NF-1:0] en_wdata,
   input  logic          clr_we,
   input  logic [NF-1:0] clr_wdata,
   output logic [NF-1:0] flags,
   output logic          irq
);
   logic [NF-1:0] en_q, clr_mask;

   assign clr_mask = clr_we ? clr_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         en_q  <= '0;
      end else begin
         flags <= (flags & ~clr_mask) | set_vec;
         if (en_we) en_q <= en_wdata;
      end
   end

   assign irq = |(flags & en_q);

   // R8: a cleared bit stays clear unless a completion set it in that cycle
   a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((flags & $past(clr_wdata & ~set_vec)) == '0));
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/sbox_xfer_seq.sv
`timescale 1ns/1ps
module sbox_xfer_seq #(
   parameter int             NRD        = 3,
   parameter int             NWR        = 3,
   parameter int             NP         = 2,
   parameter int             CNT_W      = 16,
   parameter int             FIFO_DEPTH = 4,
   parameter logic [NP-1:0]  PERIPH_IRQ = 2'b01,
   localparam int            NCH        = NRD + NWR,
   localparam int            NF         = NCH + NP,
   localparam int            CW         = $clog2(NCH),
   localparam int            PW         = (NP > 1) ? $clog2(NP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [CW-1:0]     cmd_chan,
   input  logic [PW-1:0]     cmd_periph,
   input  logic [CNT_W-1:0]  cmd_len,
   output logic              cmd_ok,
   output logic              cmd_rej,
   input  logic [NRD-1:0]    mrd_valid,
   input  logic [NRD*8-1:0]  mrd_data,
   output logic [NRD-1:0]    mrd_ready,
   output logic [NWR-1:0]    mwr_valid,
   output logic [NWR*8-1:0]  mwr_data,
   input  logic [NWR-1:0]    mwr_ready,
   output logic [NP-1:0]     prx_valid,
   output logic [NP*8-1:0]   prx_data,
   input  logic [NP-1:0]     prx_ready,
   input  logic [NP-1:0]     ptx_valid,
   input  logic [NP*8-1:0]   ptx_data,
   output logic [NP-1:0]     ptx_ready,
   input  logic [NP-1:0]     p_cmd_rdy,
   input  logic [PW-1:0]     poll_sel,
   output logic [31:0]       poll_word,
   output logic [NCH-1:0]    route_busy,
   input  logic              irq_en_we,
   input  logic [NF-1:0]     irq_en_wdata,
   input  logic              irq_clr_we,
   input  logic [NF:0]       irq_clr_wdata,
   output logic [NF-1:0]     irq_flags,
   output logic              err_flag,
   output logic              irq
);
   if (NRD < 1 || NWR < 1 || NCH < 2) begin : g_bad_chan
      $error("sbox_xfer_seq: need at least one read and one write channel");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("sbox_xfer_seq: CNT_W out of range");
   end

   logic [PW-1:0]          slot_p [NCH];
   logic [NCH-1:0]         start, s_ready, d_valid, src_done, dst_done, chan_hit;
   logic [NCH-1:0][7:0]    d_data;
   logic [NP-1:0][NCH-1:0] own;
   logic [NP-1:0]          held_p;
   logic [NF-1:0]          set_vec;
   logic                   chan_free, periph_free, accept;

   // ownership of peripherals and the peripheral-facing switchbox mux
   always_comb begin
      prx_valid = '0;
      prx_data  = '0;
      ptx_ready = '0;
      own       = '0;
      for (int p = 0; p < NP; p++) begin
         for (int c = 0; c < NCH; c++) begin
            if (route_busy[c] && int'(slot_p[c]) == p) begin
               own[p][c] = 1'b1;
               if (c < NRD) begin
                  prx_valid[p]       = d_valid[c];
                  prx_data[p*8 +: 8] = d_data[c];
               end else begin
                  ptx_ready[p] = s_ready[c];
               end
            end
         end
         held_p[p] = |own[p];
      end
   end

   // command admission
   always_comb begin
      chan_free   = 1'b0;
      periph_free = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         chan_hit[c] = (int'(cmd_chan) == c);
         if (chan_hit[c] && !route_busy[c]) chan_free = 1'b1;
      end
      for (int p = 0; p < NP; p++) begin
         if (int'(cmd_periph) == p && !held_p[p]) periph_free = 1'b1;
      end
      accept = cmd_valid && chan_free && periph_free && (cmd_len != '0);
      start  = accept ? chan_hit : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_ok   <= 1'b0;
         cmd_rej  <= 1'b0;
         err_flag <= 1'b0;
         for (int c = 0; c < NCH; c++) slot_p[c] <= '0;
      end else begin
         cmd_ok  <= accept;
         cmd_rej <= cmd_valid && !accept;
         if (cmd_valid && !accept)            err_flag <= 1'b1;
         else if (irq_clr_we && irq_clr_wdata[NF]) err_flag <= 1'b0;
         for (int c = 0; c < NCH; c++) begin
            if (start[c]) slot_p[c] <= cmd_periph;
         end
      end
   end

   // one route slot per memory channel; the channel kind picks the wiring
   for (genvar c = 0; c < NCH; c++) begin : g_slot
      logic       s_v, d_r, poll;
      logic [7:0] s_d;
      if (c < NRD) begin : g_rd
         assign s_v          = mrd_valid[c];
         assign s_d          = mrd_data[c*8 +: 8];
         assign mrd_ready[c] = s_ready[c];
         assign d_r          = prx_ready[slot_p[c]];
         assign poll         = !PERIPH_IRQ[slot_p[c]];
      end else begin : g_wr
         assign s_v                       = ptx_valid[slot_p[c]];
         assign s_d                       = ptx_data[int'(slot_p[c])*8 +: 8];
         assign mwr_valid[c-NRD]          = d_valid[c];
         assign mwr_data[(c-NRD)*8 +: 8]  = d_data[c];
         assign d_r                       = mwr_ready[c-NRD];
         assign poll                      = 1'b0;
      end

      sbx_route #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_route (
         .clk      (clk),
         .rst_n    (rst_n),
         .start    (start[c]),
         .len_in   (cmd_len),
         .dst_poll (poll),
         .dst_rdy  (p_cmd_rdy[slot_p[c]]),
         .s_valid  (s_v),
         .s_data   (s_d),
         .s_ready  (s_ready[c]),
         .d_valid  (d_valid[c]),
         .d_data   (d_data[c]),
         .d_ready  (d_r),
         .busy     (route_busy[c]),
         .src_done (src_done[c]),
         .dst_done (dst_done[c])
      );
   end

   // completion events: each half reaches only an agent that has a line
   always_comb begin
      set_vec = '0;
      for (int c = 0; c < NCH; c++) begin
         if (c < NRD) begin
            if (src_done[c]) set_vec[c] = 1'b1;
            if (dst_done[c] && PERIPH_IRQ[slot_p[c]])
               set_vec[NCH + int'(slot_p[c])] = 1'b1;
         end else begin
            if (src_done[c] && PERIPH_IRQ[slot_p[c]])
               set_vec[NCH + int'(slot_p[c])] = 1'b1;
            if (dst_done[c]) set_vec[c] = 1'b1;
         end
      end
   end

   sbx_irq_ctl #(.NF(NF)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_vec   (set_vec),
      .en_we     (irq_en_we),
      .en_wdata  (irq_en_wdata),
      .clr_we    (irq_clr_we),
      .clr_wdata (irq_clr_wdata[NF-1:0]),
      .flags     (irq_flags),
      .irq       (irq)
   );

   assign poll_word = {p_cmd_rdy[poll_sel], 30'b0, held_p[poll_sel]};

   a_r6_ok_rej_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_ok && cmd_rej));
   a_r11_err_on_rej: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_rej |-> err_flag);
   for (genvar p = 0; p < NP; p++) begin : g_chk
      a_r6_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(own[p]));
      if (!PERIPH_IRQ[p]) begin : g_nirq
         a_r5_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_flags[NCH+p]);
      end
   end
endmodule

// File: tb/tb_sbox_xfer_seq.sv
`timescale 1ns/1ps
module tb_sbox_xfer_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_chan = '0;
   logic [0:0]  cmd_periph = '0;
   logic [15:0] cmd_len = '0;
   logic        cmd_ok, cmd_rej;
   logic [2:0]  mrd_valid = '0;
   logic [23:0] mrd_data = '0;
   logic [2:0]  mrd_ready;
   logic [2:0]  mwr_valid;
   logic [23:0] mwr_data;
   logic [2:0]  mwr_ready = '0;
   logic [1:0]  prx_valid;
   logic [15:0] prx_data;
   logic [1:0]  prx_ready = '0;
   logic [1:0]  ptx_valid = '0;
   logic [15:0] ptx_data = '0;
   logic [1:0]  ptx_ready;
   logic [1:0]  p_cmd_rdy = 2'b11;
   logic [0:0]  poll_sel = '0;
   logic [31:0] poll_word;
   logic [5:0]  route_busy;
   logic        irq_en_we = 1'b0;
   logic [7:0]  irq_en_wdata = '0;
   logic        irq_clr_we = 1'b0;
   logic [8:0]  irq_clr_wdata = '0;
   logic [7:0]  irq_flags;
   logic        err_flag, irq;

   int n_vec = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   sbox_xfer_seq dut (.*);

   localparam int NV = 8;
   localparam int V_CH  [NV] = '{0, 1, 3, 5, 2, 6, 2, 4};
   localparam int V_P   [NV] = '{0, 1, 0, 1, 0, 0, 0, 1};
   localparam int V_LEN [NV] = '{5, 3, 4, 1, 0, 2, 6, 7};
   localparam int V_OK  [NV] = '{1, 1, 1, 1, 0, 0, 1, 1};
   localparam int V_FLG [NV] = '{'h41, 'h02, 'h48, 'h20, 0, 0, 'h44, 'h10};

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int ch, input int i);
      return 8'(ch * 37 + i * 11 + 5);
   endfunction

   task automatic set_src(input int ch, input int p, input bit v, input logic [7:0] d);
      if (ch < 3) begin mrd_valid[ch] = v; mrd_data[ch*8 +: 8] = d; end
      else begin ptx_valid[p] = v; ptx_data[p*8 +: 8] = d; end
   endtask

   task automatic set_snk(input int ch, input int p, input bit r);
      if (ch < 3) prx_ready[p] = r;
      else mwr_ready[ch-3] = r;
   endtask

   function automatic bit src_rdy(input int ch, input int p);
      return (ch < 3) ? mrd_ready[ch] : ptx_ready[p];
   endfunction

   function automatic bit snk_vld(input int ch, input int p);
      return (ch < 3) ? prx_valid[p] : mwr_valid[ch-3];
   endfunction

   function automatic logic [7:0] snk_dat(input int ch, input int p);
      return (ch < 3) ? prx_data[p*8 +: 8] : mwr_data[(ch-3)*8 +: 8];
   endfunction

   // called just after a falling edge; moves bytes until the route closes
   task automatic run_xfer(input int ch, input int p, input int n,
                           input int s0, input int g0, input int lim);
      int sent = s0;
      int got  = g0;
      for (int k = 0; k < lim; k++) begin
         set_src(ch, p, sent < n, pat(ch, sent));
         set_snk(ch, p, 1'b1);
         #1;
         if (sent < n && src_rdy(ch, p)) sent++;
         if (snk_vld(ch, p)) begin
            chk("R9 byte order", snk_dat(ch, p), pat(ch, got));
            got++;
         end
         if (!route_busy[ch] && got == n) break;
         @(negedge clk);
      end
      set_src(ch, p, 1'b0, 8'h00);
      set_snk(ch, p, 1'b0);
      chk("R9 byte count", got, n);
   endtask

   task automatic send_cmd(input int ch, input int p, input int len);
      @(negedge clk);
      cmd_chan = 3'(ch); cmd_periph = 1'(p); cmd_len = 16'(len);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      #1;
   endtask

   task automatic clr_write(input logic [8:0] v);
      @(negedge clk);
      irq_clr_we = 1'b1; irq_clr_wdata = v;
      @(negedge clk);
      irq_clr_we = 1'b0;
      #1;
   endtask

   task automatic en_write(input logic [7:0] v);
      @(negedge clk);
      irq_en_we = 1'b1; irq_en_wdata = v;
      @(negedge clk);
      irq_en_we = 1'b0;
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         n_bad++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int sent, got;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // reset state
      chk("R8 reset flags", irq_flags, 0);
      chk("R8 reset irq", irq, 0);
      chk("R8 reset busy", route_busy, 0);
      chk("R11 reset err", err_flag, 0);
      chk("R1 reset cmd_ok", cmd_ok, 0);
      chk("R1 reset src ready", mrd_ready, 0);
      en_write(8'hFF);

      // vector table
      for (int i = 0; i < NV; i++) begin
         send_cmd(V_CH[i], V_P[i], V_LEN[i]);
         chk("R6 accept", cmd_ok, V_OK[i]);
         chk("R7 refuse", cmd_rej, 1 - V_OK[i]);
         if (V_OK[i] != 0) begin
            run_xfer(V_CH[i], V_P[i], V_LEN[i], 0, 0, 3000);
            @(negedge clk); #1;
            chk("R2 R3 R10 flags", irq_flags, V_FLG[i]);
            chk("R8 irq", irq, 1);
         end else begin
            chk("R7 no route", route_busy, 0);
            chk("R11 err set", err_flag, 1);
         end
         clr_write(9'h1FF);
         chk("R8 w1c all", irq_flags, 0);
         chk("R11 err cleared", err_flag, 0);
      end

      // R1: step ordering, cycle exact
      @(negedge clk);
      cmd_chan = 3'd0; cmd_periph = 1'b0; cmd_len = 16'd2; cmd_valid = 1'b1;
      set_src(0, 0, 1'b1, pat(0, 0));
      prx_ready[0] = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      #1;
      chk("R1 cmd_ok", cmd_ok, 1);
      chk("R1 link no src", mrd_ready[0], 0);
      @(negedge clk); #1;
      chk("R1 src armed", mrd_ready[0], 1);
      chk("R1 dst not yet", prx_valid[0], 0);
      @(negedge clk); #1;
      chk("R1 dst armed", prx_valid[0], 1);
      run_xfer(0, 0, 2, 1, 0, 100);
      clr_write(9'h1FF);

      // R2 R4 R6 R11: destination stalled
      send_cmd(0, 0, 3);
      sent = 0;
      for (int k = 0; k < 50 && sent < 3; k++) begin
         set_src(0, 0, 1'b1, pat(0, sent));
         #1;
         if (mrd_ready[0]) sent++;
         @(negedge clk);
      end
      set_src(0, 0, 1'b0, 8'h00);
      #1;
      chk("R2 src flag early", irq_flags[0], 1);
      chk("R2 dst flag absent", irq_flags[6], 0);
      repeat (6) @(negedge clk);
      #1;
      chk("R4 route held", route_busy[0], 1);
      poll_sel = 1'b0; #1;
      chk("R5 poll held bit", poll_word[0], 1);
      send_cmd(0, 1, 1);
      chk("R6 busy channel", cmd_rej, 1);
      send_cmd(1, 0, 1);
      chk("R6 held periph", cmd_rej, 1);
      chk("R6 no new route", route_busy[1], 0);
      chk("R11 err sticky", err_flag, 1);
      clr_write(9'h100);
      chk("R11 err clear", err_flag, 0);
      chk("R8 untouched flag", irq_flags[0], 1);
      got = 0;
      @(negedge clk);
      prx_ready[0] = 1'b1;
      for (int k = 0; k < 50; k++) begin
         #1;
         if (prx_valid[0]) begin
            chk("R9 stalled order", prx_data[7:0], pat(0, got));
            got++;
         end
         if (got == 3) break;
         @(negedge clk);
      end
      @(negedge clk); #1;
      chk("R4 drain busy", route_busy[0], 1);
      chk("R3 dst flag timing", irq_flags[6], 0);
      @(negedge clk); #1;
      chk("R4 drain busy2", route_busy[0], 1);
      chk("R3 dst flag set", irq_flags[6], 1);
      @(negedge clk); #1;
      chk("R4 released", route_busy[0], 0);
      prx_ready[0] = 1'b0;
      clr_write(9'h1FF);

      // R5: peripheral without interrupt, gated by command-ready
      p_cmd_rdy[1] = 1'b0;
      send_cmd(1, 1, 2);
      run_xfer(1, 1, 2, 0, 0, 20);
      #1;
      chk("R5 wait ready", route_busy[1], 1);
      poll_sel = 1'b1; #1;
      chk("R5 poll busy", poll_word[31], 0);
      chk("R5 no periph flag", irq_flags[7], 0);
      @(negedge clk);
      p_cmd_rdy[1] = 1'b1;
      #1;
      chk("R5 poll ready", poll_word[31], 1);
      @(negedge clk); #1;
      chk("R5 drain", route_busy[1], 1);
      @(negedge clk); #1;
      chk("R5 released", route_busy[1], 0);
      chk("R5 flags", irq_flags, 'h02);

      // R8: enable masking and write-one-to-clear
      en_write(8'h01);
      chk("R8 masked", irq, 0);
      en_write(8'h02);
      chk("R8 enabled", irq, 1);
      clr_write(9'h002);
      chk("R8 cleared", irq_flags, 0);
      chk("R8 irq low", irq, 0);

      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule